// File: doc/BRIEF.md
# Serial Sampling-ADC Port Model

This block is a synthesizable behavioural stand-in for the digital half of a 12-bit successive-approximation converter with a three-wire serial port. A controller under test drives an active-low select and a serial clock. The block answers with a three-state data line, given as a data bit plus an output enable. A 12-bit sample word from the surrounding bench takes the place of the analog result. Two flags show whether the sample/hold is holding and whether the converter is powered. A third flag shows whether the data of the current frame is genuine.

The model runs on a fast system clock. Select and serial clock pass through two-stage synchronizers, and the block acts on their edges. Each frame carries sixteen bit slots: two zeros, the twelve data bits with the most significant first, then two zeros. The point at which select is released inside a frame sets what follows. The frame can end normally, it can abort and leave the part powered, or it can put the part to sleep. A sleeping part returns to full power only after a complete dummy frame.

Top module: `adc_port_model`

## Requirements
- R1: After reset the part is asleep (awake_o=0), sdo_oe_o=0, hold_o=1 and valid_o=0.
- R2: A falling select edge enables the output, drives a 0 on sdo_o and sets hold_o=1.
- R3: After the k-th falling serial-clock edge of a frame (k=1..15), sdo_o carries bit 15-k of the 16-bit word {2'b00, sample, 2'b00}. Bit 15 is the most significant.
- R4: The 16th falling edge disables the output. Further falling edges in the same frame leave it disabled.
- R5: While select is high, the output is disabled.
- R6: In a powered frame, hold_o stays 1 until the 14th falling edge and then drops to 0.
- R7: In a powered frame, releasing select after 2 to 9 falling edges puts the part to sleep (awake_o=0, hold_o=1, valid_o=0).
- R8: In a powered frame, releasing select after 10 to 15 falling edges ends the frame with the output disabled, the part still awake and hold_o=0.
- R9: A frame that starts while the part is asleep is a wake frame with valid_o=0. In it, hold_o drops at the 1st falling edge and awake_o rises at the 16th. If select is released before the 16th edge, the part stays asleep with hold_o=1.
- R10: A frame that starts while the part is powered has valid_o=1.
- R11: In a powered frame, releasing select after 0 or 1 falling edges leaves the part awake with hold_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sample_i | input | 12 | Word returned as the conversion result |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for the data line |
| hold_o | output | 1 | 1 while the sample/hold is in hold |
| awake_o | output | 1 | 1 while the part is fully powered |
| valid_o | output | 1 | 1 while the current frame carries genuine data |

## Verification
A wrong edge count shows up within one serial-clock period. The symptoms are a misplaced data bit, a late or early release of the enable, or a hold flag that drops at the wrong edge. A wrong power state is not visible at once. It first shows at the next select transition, as a valid flag of the wrong value or a wake frame that never raises awake_o. For that reason, random frame lengths are chained so that each frame checks the state left behind by the frame before it.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    PWR_SLEEP = 2'd0,
    PWR_WAKE  = 2'd1,
    PWR_ON    = 2'd2
  } pwr_e;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s0_q, s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = s1_q[i] & ~s2_q[i];
    assign fall_o[i] = ~s1_q[i] & s2_q[i];
  end
  assign lvl_o = s2_q;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_port_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned HOLD_AT   = 14,
  parameter int unsigned SLEEP_LO  = 2,
  parameter int unsigned SLEEP_HI  = 10,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sck_fall_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output pwr_e             pwr_o,
  output logic             hold_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] LenC  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] HoldC = CNT_W'(HOLD_AT);
  localparam logic [CNT_W-1:0] SlLoC = CNT_W'(SLEEP_LO);
  localparam logic [CNT_W-1:0] SlHiC = CNT_W'(SLEEP_HI);

  logic             active_q, hold_q, valid_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  pwr_e             pwr_q;

  assign cnt_nx  = cnt_q + 1'b1;
  assign load_o  = cs_fall_i;
  assign shift_o = sck_fall_i & active_q & (cnt_q < LenC) & ~cs_fall_i & ~cs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      pwr_q    <= PWR_SLEEP;
      hold_q   <= 1'b1;
      valid_q  <= 1'b0;
    end else if (cs_fall_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      hold_q   <= 1'b1;
      valid_q  <= (pwr_q == PWR_ON);
      if (pwr_q == PWR_SLEEP) pwr_q <= PWR_WAKE;
    end else if (cs_rise_i) begin
      active_q <= 1'b0;
      unique case (pwr_q)
        PWR_WAKE: begin
          pwr_q  <= PWR_SLEEP;
          hold_q <= 1'b1;
        end
        PWR_ON: begin
          if (cnt_q >= SlLoC && cnt_q < SlHiC) begin
            pwr_q   <= PWR_SLEEP;
            hold_q  <= 1'b1;
            valid_q <= 1'b0;
          end else begin
            hold_q <= 1'b0;
          end
        end
        default: hold_q <= 1'b1;
      endcase
    end else if (shift_o) begin
      cnt_q <= cnt_nx;
      if (pwr_q == PWR_WAKE) hold_q <= 1'b0;
      if (pwr_q == PWR_ON && cnt_nx == HoldC) hold_q <= 1'b0;
      if (cnt_nx == LenC) begin
        active_q <= 1'b0;
        if (pwr_q == PWR_WAKE) pwr_q <= PWR_ON;
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign pwr_o    = pwr_q;
  assign hold_o   = hold_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/adc_shift.sv
module adc_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model
  import adc_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned LEAD_ZEROS  = 2,
  parameter int unsigned TRAIL_ZEROS = 2,
  parameter int unsigned SLEEP_LO    = 2,
  parameter int unsigned SLEEP_HI    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              hold_o,
  output logic              awake_o,
  output logic              valid_o
);
  localparam int unsigned FRAME_LEN = LEAD_ZEROS + DATA_W + TRAIL_ZEROS;
  localparam int unsigned HOLD_AT   = LEAD_ZEROS + DATA_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

  // bit 0: select (idles high), bit 1: serial clock
  logic [1:0] lvl, rise, fall;
  logic       cs_lvl;
  logic       load, shift, active, shd;
  logic [CNT_W-1:0] cnt;
  pwr_e       pwr;
  logic [FRAME_LEN-1:0] word;

  adc_edge_sync #(.N(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );
  assign cs_lvl = lvl[0];

  adc_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN), .HOLD_AT(HOLD_AT),
    .SLEEP_LO(SLEEP_LO), .SLEEP_HI(SLEEP_HI), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_fall_i (fall[0]),
    .cs_rise_i (rise[0]),
    .sck_fall_i(fall[1]),
    .load_o    (load),
    .shift_o   (shift),
    .active_o  (active),
    .cnt_o     (cnt),
    .pwr_o     (pwr),
    .hold_o    (hold_o),
    .valid_o   (valid_o)
  );

  assign word = {{LEAD_ZEROS{1'b0}}, sample_i, {TRAIL_ZEROS{1'b0}}};

  adc_shift #(.W(FRAME_LEN)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .word_i (word),
    .bit_o  (shd)
  );

  assign sdo_o    = active & shd;
  assign sdo_oe_o = active;
  assign awake_o  = (pwr == PWR_ON);
endmodule

// File: rtl/adc_port_model_chk.sv
module adc_port_model_chk
  import adc_port_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned FRAME_LEN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_lvl_i,
  input logic             sdo_oe_i,
  input logic             hold_i,
  input logic             awake_i,
  input logic             valid_i,
  input pwr_e             pwr_i,
  input logic [CNT_W-1:0] cnt_i
);
  // R5
  cs_high_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_lvl_i |-> !sdo_oe_i);
  // R9
  sleep_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i == PWR_SLEEP) |-> hold_i);
  // R10
  valid_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> awake_i);
  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(FRAME_LEN));
  // R2
  start_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_i) |-> hold_i);
  // R7
  sleep_entry_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(awake_i) |-> !sdo_oe_i);
endmodule

bind adc_port_model adc_port_model_chk #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_lvl_i(cs_lvl),
  .sdo_oe_i(sdo_oe_o),
  .hold_i  (hold_o),
  .awake_i (awake_o),
  .valid_i (valid_o),
  .pwr_i   (pwr),
  .cnt_i   (cnt)
);

// File: tb/adc_port_model_tb.sv
module adc_port_model_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, hold, awake, valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int mpwr = 0; // 0 asleep, 1 wake frame, 2 powered

  always #4 clk = ~clk;

  adc_port_model u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .hold_o(hold), .awake_o(awake), .valid_o(valid)
  );

  function automatic logic exp_bit(input logic [11:0] d, input int k);
    logic [15:0] w;
    w = {2'b00, d, 2'b00};
    return w[15-k];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic frame(input logic [11:0] d, input int n);
    bit was_on;
    was_on = (mpwr == 2);
    sample = d;
    cs_n = 1'b0;
    settle();
    check(sdo_oe === 1'b1, "R2 oe", sdo_oe, 1);
    check(sdo === 1'b0, "R2 first zero", sdo, 0);
    check(hold === 1'b1, "R2 hold", hold, 1);
    if (was_on) check(valid === 1'b1, "R10 valid", valid, 1);
    else        check(valid === 1'b0, "R9 valid", valid, 0);
    if (mpwr == 0) mpwr = 1;
    for (int k = 1; k <= n; k++) begin
      sck = 1'b1;
      settle();
      sck = 1'b0;
      settle();
      if (k < 16) begin
        check(sdo_oe === 1'b1, "R3 oe", sdo_oe, 1);
        check(sdo === exp_bit(d, k), "R3 bit", sdo, exp_bit(d, k));
      end else begin
        check(sdo_oe === 1'b0, "R4 oe", sdo_oe, 0);
      end
      if (mpwr == 2) check(hold === (k < 14), "R6 hold", hold, (k < 14));
      if (mpwr == 1) check(hold === 1'b0, "R9 hold", hold, 0);
      if (k == 16 && mpwr == 1) begin
        mpwr = 2;
        check(awake === 1'b1, "R9 awake", awake, 1);
      end
    end
    cs_n = 1'b1;
    settle();
    check(sdo_oe === 1'b0, "R5 oe", sdo_oe, 0);
    if (mpwr == 1) begin
      mpwr = 0;
      check(awake === 1'b0 && hold === 1'b1, "R9 abort", {awake, hold}, 1);
    end else if (was_on && n >= 2 && n < 10) begin
      mpwr = 0;
      check(awake === 1'b0 && hold === 1'b1 && valid === 1'b0, "R7 sleep",
            {awake, hold, valid}, 3'b010);
    end else if (was_on && n >= 10 && n < 16) begin
      check(awake === 1'b1 && hold === 1'b0, "R8 abort", {awake, hold}, 2);
    end else if (was_on && n < 2) begin
      check(awake === 1'b1 && hold === 1'b0, "R11 early", {awake, hold}, 2);
    end else if (mpwr == 2) begin
      check(awake === 1'b1 && hold === 1'b0, "R6 end", {awake, hold}, 2);
    end
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(awake === 1'b0 && sdo_oe === 1'b0 && hold === 1'b1 && valid === 1'b0,
          "R1 reset", {awake, sdo_oe, hold, valid}, 4'b0010);
    rst_n = 1'b1;
    settle();
    check(awake === 1'b0 && hold === 1'b1, "R1 after release", {awake, hold}, 1);
    frame(12'h3C5, 8);    // R9 wake frame aborted
    frame(12'hFFF, 16);   // R9 full wake frame
    frame(12'hA5C, 16);   // R3 R10 normal
    frame(12'hFFF, 18);   // R4 extra edges
    frame(12'h001, 14);   // R8 release at 14
    frame(12'h800, 12);   // R8
    frame(12'h7AA, 1);    // R11
    frame(12'h555, 0);    // R11
    frame(12'h123, 5);    // R7 sleep
    frame(12'h0F0, 16);   // wake again
    frame(12'hABC, 2);    // R7 lower bound
    frame(12'h000, 16);   // wake
    frame(12'hDEF, 9);    // R7 upper bound
    frame(12'h000, 16);   // wake
    frame(12'h9A9, 10);   // R8 lower bound
    for (int i = 0; i < 40; i++) begin
      frame(12'($urandom), int'($urandom_range(0, 18)));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20 rst_n = 1'b0;
  end
endmodule